// File: doc/BRIEF.md
# SECDED Hamming Codec

This block protects a data word held in memory against single-bit upsets. On the write side, it spreads the data across a Hamming codeword. Check bits sit at the power-of-two positions, and one extra bit at the top of the word gives even parity over everything else. On the read side, it recomputes the checks over the stored word to form a syndrome, and it tests the overall parity. The two results together give one of three outcomes: the word is clean, a single flipped bit was repaired, or the word holds damage that cannot be repaired.

Both directions are purely combinational, so the block can sit directly in a memory's write and read data paths. The data width is a parameter, and the number of check bits follows from it. Four data bits give an 8-bit codeword. Sixty-four data bits give a 72-bit codeword with eight protection bits. The overhead grows roughly as one plus the base-2 logarithm of the data width.

Top module: `secded_codec`

## Requirements
- R1: For DATA_W data bits the codeword has CODE_W = DATA_W + r + 1 bits, where r is the smallest count with 2^r >= DATA_W + r + 1 (4 gives 8, 64 gives 72). Codeword position i (1-based) is bit i-1. Check bits occupy positions 1, 2, 4, 8 and so on. Data bit 0 upward fills the remaining positions below CODE_W in ascending order. The overall parity bit is bit CODE_W-1. For 4 data bits, data 4'h0 encodes to 8'h00, 4'hF to 8'hFF and 4'h1 to 8'h87.
- R2: The check bit at position 2^k is the XOR of every other position in 1..CODE_W-1 whose index has bit k set.
- R3: Every codeword from the encoder has an even number of ones.
- R4: A read word with no flipped bits returns the data unchanged, with err_corr = 0, err_uncorr = 0 and err_pos = 0.
- R5: A read word with exactly one flipped bit at a position p in 1..CODE_W-1 returns the original data, with err_corr = 1, err_uncorr = 0 and err_pos = p.
- R6: A read word whose only flipped bit is the overall parity bit returns the data unchanged, with err_corr = 1 and err_pos = CODE_W.
- R7: A read word with exactly two flipped bits gives err_uncorr = 1, err_corr = 0 and err_pos = 0. rd_data then carries the data bits of the read word without any repair.
- R8: A nonzero syndrome together with a parity mismatch, where the syndrome names a position above CODE_W-1, is treated as uncorrectable. An example is flips at positions 1, 8 and 64 of a 72-bit word. The result is err_uncorr = 1 and err_pos = 0, and no bit is repaired.
- R9: err_corr and err_uncorr are never both 1. err_pos is nonzero only while err_corr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | DATA_W | Data to protect |
| wr_code | output | CODE_W | Protected codeword to store |
| rd_code | input | CODE_W | Codeword read back from storage |
| rd_data | output | DATA_W | Data recovered from rd_code, repaired when a single error was found |
| err_corr | output | 1 | A single error was found and repaired |
| err_uncorr | output | 1 | Damage found that cannot be repaired |
| err_pos | output | POS_W | 1-based position of the repaired bit, 0 when none |

## Verification
The bound checker looks at every cycle's port values and tests several properties. It checks that the two flags never coexist and that a position is reported only with a repair. It checks that every written codeword has even weight, and that the repaired position lies inside the codeword. It also checks that a clean, parity-only or uncorrectable outcome passes the read data through unmodified.

Other behaviours need a known injected error pattern, so only the bench's scenarios can show them. These are whether the check bits have the right values, whether a single flip is repaired at the right position, and whether two flips or an out-of-range syndrome are classed as uncorrectable. The bench covers these with random words and with directed flips at every position.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // smallest number of Hamming check bits for a data width
   function automatic int chk_count(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // 1-based codeword position carrying data bit j (0-based)
   function automatic int data_slot(input int j);
      int p;
      int seen;
      p    = 0;
      seen = -1;
      while (seen < j) begin
         p++;
         if ((p & (p - 1)) != 0) seen++;
      end
      return p;
   endfunction

   function automatic int pos_width(input int code_w);
      return $clog2(code_w + 1);
   endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
   parameter int HAM_W = 71,
   parameter int CHK_W = 7
) (
   input  logic [HAM_W-1:0] word,
   output logic [CHK_W-1:0] syn
);
   always_comb begin
      syn = '0;
      for (int p = 1; p <= HAM_W; p++) begin
         for (int k = 0; k < CHK_W; k++) begin
            if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ word[p-1];
         end
      end
   end
endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = chk_count(DATA_W),
   parameter int HAM_W  = DATA_W + CHK_W,
   parameter int CODE_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W-1:0] code
);
   wire  [HAM_W-1:0] spread;
   wire  [HAM_W-1:0] chk_spread;
   logic [CHK_W-1:0] chk;

   for (genvar j = 0; j < DATA_W; j++) begin : g_place
      assign spread[data_slot(j)-1] = data[j];
   end
   for (genvar k = 0; k < CHK_W; k++) begin : g_hole
      assign spread[(1 << k) - 1]     = 1'b0;
      assign chk_spread[(1 << k) - 1] = chk[k];
   end
   for (genvar j = 0; j < DATA_W; j++) begin : g_zero
      assign chk_spread[data_slot(j)-1] = 1'b0;
   end

   secded_syndrome #(.HAM_W(HAM_W), .CHK_W(CHK_W)) u_chk (
      .word (spread),
      .syn  (chk)
   );

   logic [HAM_W-1:0] body;
   assign body = spread | chk_spread;
   assign code = {^body, body};
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = chk_count(DATA_W),
   parameter int HAM_W  = DATA_W + CHK_W,
   parameter int CODE_W = HAM_W + 1,
   parameter int POS_W  = pos_width(CODE_W)
) (
   input  logic [CODE_W-1:0] code,
   output logic [DATA_W-1:0] data,
   output logic              corr,
   output logic              uncorr,
   output logic [POS_W-1:0]  pos
);
   logic [HAM_W-1:0] body;
   logic [HAM_W-1:0] flip;
   logic [HAM_W-1:0] fixed;
   logic [CHK_W-1:0] syn;
   logic             par_bad;

   assign body    = code[HAM_W-1:0];
   assign par_bad = ^code;

   secded_syndrome #(.HAM_W(HAM_W), .CHK_W(CHK_W)) u_syn (
      .word (body),
      .syn  (syn)
   );

   always_comb begin
      corr   = 1'b0;
      uncorr = 1'b0;
      pos    = '0;
      flip   = '0;
      if (syn == '0) begin
         if (par_bad) begin
            corr = 1'b1;
            pos  = POS_W'(CODE_W);
         end
      end else if (par_bad && (int'(syn) <= HAM_W)) begin
         corr = 1'b1;
         pos  = POS_W'(syn);
         for (int p = 1; p <= HAM_W; p++) flip[p-1] = (int'(syn) == p);
      end else begin
         uncorr = 1'b1;
      end
   end

   assign fixed = body ^ flip;

   for (genvar j = 0; j < DATA_W; j++) begin : g_pick
      assign data[j] = fixed[data_slot(j)-1];
   end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int CHK_W  = chk_count(DATA_W),
   localparam int CODE_W = DATA_W + CHK_W + 1,
   localparam int POS_W  = pos_width(CODE_W)
) (
   input  logic [DATA_W-1:0] wr_data,
   output logic [CODE_W-1:0] wr_code,
   input  logic [CODE_W-1:0] rd_code,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_corr,
   output logic              err_uncorr,
   output logic [POS_W-1:0]  err_pos
);
   if (DATA_W < 1) begin : g_bad_width
      $error("secded_codec: DATA_W must be at least 1");
   end
   if ((1 << CHK_W) < DATA_W + CHK_W + 1) begin : g_bad_chk
      $error("secded_codec: too few check bits");
   end

   secded_encoder #(.DATA_W(DATA_W)) u_enc (
      .data (wr_data),
      .code (wr_code)
   );

   secded_decoder #(.DATA_W(DATA_W)) u_dec (
      .code   (rd_code),
      .data   (rd_data),
      .corr   (err_corr),
      .uncorr (err_uncorr),
      .pos    (err_pos)
   );
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CODE_W = DATA_W + chk_count(DATA_W) + 1,
   parameter int POS_W  = pos_width(CODE_W)
) (
   input logic [DATA_W-1:0] wr_data,
   input logic [CODE_W-1:0] wr_code,
   input logic [CODE_W-1:0] rd_code,
   input logic [DATA_W-1:0] rd_data,
   input logic              err_corr,
   input logic              err_uncorr,
   input logic [POS_W-1:0]  err_pos
);
   wire [DATA_W-1:0] raw;
   for (genvar j = 0; j < DATA_W; j++) begin : g_raw
      assign raw[j] = rd_code[data_slot(j)-1];
   end

   always_comb begin
      // R9
      p_flags_excl_r9: assert (!(err_corr && err_uncorr))
         else $error("both error flags set");
      p_pos_only_corr_r9: assert (err_corr || err_pos == '0)
         else $error("position reported without repair");
      // R3
      p_wr_even_r3: assert ($countones(wr_code) % 2 == 0)
         else $error("written codeword has odd weight");
      // R5
      p_pos_range_r5: assert (!err_corr || (err_pos != '0 && int'(err_pos) <= CODE_W))
         else $error("repair position out of range");
      // R4
      p_clean_pass_r4: assert (err_corr || err_uncorr || rd_data == raw)
         else $error("clean word altered");
      // R7
      p_uncorr_raw_r7: assert (!err_uncorr || rd_data == raw)
         else $error("uncorrectable word altered");
      // R6
      p_par_only_r6: assert (!(err_corr && int'(err_pos) == CODE_W) || rd_data == raw)
         else $error("parity-only repair altered data");
   end
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W)) u_secded_chk (
   .wr_data    (wr_data),
   .wr_code    (wr_code),
   .rd_code    (rd_code),
   .rd_data    (rd_data),
   .err_corr   (err_corr),
   .err_uncorr (err_uncorr),
   .err_pos    (err_pos)
);

// File: tb/tb_secded_codec.sv
module tb_secded_codec;
   localparam int DW = 64;
   localparam int CW = 72;
   localparam int PW = 7;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [DW-1:0] wr_data, rd_data;
   logic [CW-1:0] wr_code, rd_code;
   logic          err_corr, err_uncorr;
   logic [PW-1:0] err_pos;

   logic [3:0] w4_wr_data, w4_rd_data;
   logic [7:0] w4_wr_code, w4_rd_code;
   logic       w4_corr, w4_uncorr;
   logic [3:0] w4_pos;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   secded_codec #(.DATA_W(DW)) dut (
      .wr_data, .wr_code, .rd_code, .rd_data,
      .err_corr, .err_uncorr, .err_pos
   );

   secded_codec #(.DATA_W(4)) dut_w4 (
      .wr_data (w4_wr_data), .wr_code (w4_wr_code), .rd_code (w4_rd_code),
      .rd_data (w4_rd_data), .err_corr (w4_corr), .err_uncorr (w4_uncorr),
      .err_pos (w4_pos)
   );

   function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
      logic [CW-1:0] c;
      int j;
      c = '0;
      j = 0;
      for (int p = 1; p < CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            c[p-1] = d[j];
            j++;
         end
      end
      for (int k = 0; (1 << k) < CW; k++) begin
         logic b;
         b = 1'b0;
         for (int p = 1; p < CW; p++) if ((p & (1 << k)) != 0) b = b ^ c[p-1];
         c[(1 << k) - 1] = b;
      end
      c[CW-1] = ^c[CW-2:0];
      return c;
   endfunction

   function automatic logic [DW-1:0] ref_raw(input logic [CW-1:0] c);
      logic [DW-1:0] d;
      int j;
      d = '0;
      j = 0;
      for (int p = 1; p < CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            d[j] = c[p-1];
            j++;
         end
      end
      return d;
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic read_check(input string req, input logic [CW-1:0] code,
                             input logic [DW-1:0] exp_d, input logic ec,
                             input logic eu, input int ep);
      @(negedge clk);
      rd_code = code;
      #1;
      check({req, " data"}, 128'(rd_data), 128'(exp_d));
      check({req, " corr"}, 128'(err_corr), 128'(ec));
      check({req, " uncorr"}, 128'(err_uncorr), 128'(eu));
      check({req, " pos"}, 128'(err_pos), 128'(ep));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic [CW-1:0] c;
      void'($urandom(32'd20231));
      wr_data = '0;
      rd_code = '0;
      w4_wr_data = '0;
      w4_rd_code = '0;
      @(negedge clk);
      #1;
      // initial state: all-zero word is clean (R4)
      check("R4 idle code", 128'(wr_code), 128'(0));
      check("R4 idle flags", 128'({err_corr, err_uncorr, err_pos}), 128'(0));

      // R1 layout on the 4-bit size
      @(negedge clk); w4_wr_data = 4'h0; #1;
      check("R1 w4 0", 128'(w4_wr_code), 128'(8'h00));
      @(negedge clk); w4_wr_data = 4'hF; #1;
      check("R1 w4 F", 128'(w4_wr_code), 128'(8'hFF));
      @(negedge clk); w4_wr_data = 4'h1; #1;
      check("R1 w4 1", 128'(w4_wr_code), 128'(8'h87));
      // R5 on 4-bit: flip position 5 of 8'h87
      @(negedge clk); w4_rd_code = 8'h87 ^ 8'h10; #1;
      check("R5 w4 data", 128'(w4_rd_data), 128'(4'h1));
      check("R5 w4 flags", 128'({w4_corr, w4_uncorr, w4_pos}), 128'({1'b1, 1'b0, 4'd5}));

      // random words mixed across error modes
      for (int it = 0; it < 400; it++) begin
         d = {$urandom, $urandom};
         @(negedge clk);
         wr_data = d;
         #1;
         check("R2 encode", 128'(wr_code), 128'(ref_enc(d)));
         check("R3 even", 128'($countones(wr_code) % 2), 128'(0));
         c = ref_enc(d);
         case (it % 4)
            0: read_check("R4 clean", c, d, 1'b0, 1'b0, 0);
            1: begin
               int p;
               p = 1 + int'($urandom % (CW - 1));
               c[p-1] = ~c[p-1];
               read_check("R5 single", c, d, 1'b1, 1'b0, p);
            end
            2: begin
               c[CW-1] = ~c[CW-1];
               read_check("R6 parity", c, d, 1'b1, 1'b0, CW);
            end
            default: begin
               int a;
               int b;
               a = 1 + int'($urandom % CW);
               b = 1 + int'($urandom % (CW - 1));
               if (b >= a) b++;
               c[a-1] = ~c[a-1];
               c[b-1] = ~c[b-1];
               read_check("R7 double", c, ref_raw(c), 1'b0, 1'b1, 0);
            end
         endcase
      end

      // R5 every position on one word
      d = 64'hA5C3_0F1E_9B72_4D68;
      for (int p = 1; p < CW; p++) begin
         c = ref_enc(d);
         c[p-1] = ~c[p-1];
         read_check("R5 sweep", c, d, 1'b1, 1'b0, p);
      end

      // R8 syndrome beyond the word with odd parity
      c = ref_enc(d);
      c[0]  = ~c[0];
      c[7]  = ~c[7];
      c[63] = ~c[63];
      read_check("R8 out of range", c, ref_raw(c), 1'b0, 1'b1, 0);

      // R9 flags exclusive on a double error next to parity
      c = ref_enc(d);
      c[CW-1] = ~c[CW-1];
      c[2]    = ~c[2];
      read_check("R9 excl", c, ref_raw(c), 1'b0, 1'b1, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule